// File: doc/BRIEF.md
# Byte-Wide EPROM Control and Signature Model

This block is a synthesizable behavioural model of the control side of a byte-wide, UV-erasable programmable memory. It is meant to be placed in a testbench, or used as a reference target, when a memory programmer or boot controller needs checking. Active-low chip select, output enable and program strobe, together with three supply flags, choose one of six operating modes. In read and verify modes the model drives the data bus. In every other mode the bus is released. Analog conditions appear only as flags: the programming supply raised, the core supply raised, and the identification voltage present on the address line.

The array is a small parameterized store. A program pulse can only clear bits, and only an erase sets them again. The model counts a pulse only when the strobe falls and then rises while the part is set up for programming. A strobe held low for longer than a parameterized number of clocks is discarded and raises a sticky error flag. When the identification flag is set with all controls low and the upper address bits zero, the bus carries one of two signature bytes chosen by address bit 0.

Top module: `eprom_ctl`

## Requirements
- R1: `mode` reports the decoded mode, with codes 0 standby, 1 read, 2 output off, 3 program, 4 verify, 5 inhibit. "High voltage" (hv) means `vpp_hi` and `vcc_hi` are both set. The decode is as follows. `ce_n`=1 gives inhibit when hv is set and standby otherwise. `ce_n`=0 with `oe_n`=1 gives program when hv is set and `pgm_n`=0, and output off otherwise. `ce_n`=0 with `oe_n`=0 gives read without hv, verify with hv and `pgm_n`=1, and output off with hv and `pgm_n`=0.
- R2: `dout_en` is 1 only in read and verify modes. Whenever `dout_en` is 0, `dout` is 8'h00.
- R3: In read mode, `dout` is the array byte at `addr`, whatever the values of `pgm_n` and of `vpp_hi` alone.
- R4: After reset, and one clock after `erase_all` is seen high, every byte reads 8'hFF.
- R5: A program pulse works as follows. The strobe falls while `ce_n`=0, `oe_n`=1 and hv is set. It then stays low for 1 to MAX_LOW clock edges, and rises with the same setup still present. On that rising clock the byte at `addr` becomes old AND `din`, so bits can only clear.
- R6: In verify mode, `dout` is the array byte at `addr`.
- R7: A strobe pulse with `ce_n`=1, or with only one of the two supply flags set, leaves the array unchanged.
- R8: If the strobe is low for more than MAX_LOW consecutive clock edges in a pulse, that pulse is discarded and `pulse_err` goes to 1. `pulse_err` stays at 1 until reset.
- R9: In read mode with `id_hv`=1, `pgm_n`=0 and `addr[ADDR_W-1:1]`=0, `dout` is 8'h8F when `addr[0]`=0 and 8'h86 when `addr[0]`=1. If any of these conditions fails, the array byte is read instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Active-low reset; erases the array |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| addr | input | ADDR_W | Byte address |
| vpp_hi | input | 1 | Programming supply raised |
| vcc_hi | input | 1 | Core supply raised |
| id_hv | input | 1 | Identification voltage present on the address pin |
| erase_all | input | 1 | Flash the whole array back to ones |
| din | input | 8 | Data presented on the bus for programming |
| dout | output | 8 | Data driven onto the bus |
| dout_en | output | 1 | Bus drive enable (0 means high impedance) |
| mode | output | 3 | Decoded operating mode |
| pulse_err | output | 1 | Sticky flag for an over-long program strobe |

## Verification
The bench builds the block with ADDR_W=4 and MAX_LOW=4, so the whole 16-byte array is swept on every read-back. With these values the model's array stays in step with the bench's AND-only model, both after two programming passes and after an erase. They also put a strobe of exactly MAX_LOW and one of MAX_LOW+1 edges within a few cycles of each other. All 32 combinations of the five mode-selecting inputs are applied, and the signature is probed at the addresses either side of the select bit.

// File: rtl/eprom_ctl.sv
module eprom_ctl #(
  parameter int ADDR_W  = 8,
  parameter int MAX_LOW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              vpp_hi,
  input  logic              vcc_hi,
  input  logic              id_hv,
  input  logic              erase_all,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic [2:0]        mode,
  output logic              pulse_err
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = $clog2(MAX_LOW + 1);
  localparam logic [2:0] M_STBY = 3'd0, M_READ = 3'd1, M_ODIS = 3'd2,
                         M_PROG = 3'd3, M_VRFY = 3'd4, M_INHB = 3'd5;
  localparam logic [7:0] SIG_MFR = 8'h8F, SIG_DEV = 8'h86;

  logic [7:0]    mem [DEPTH];
  logic          hv, setup, pgm_q, armed, wr, sig_hit;
  logic [CW-1:0] low_cnt;

  assign hv    = vpp_hi & vcc_hi;
  assign setup = !ce_n && oe_n && hv;

  always_comb begin
    if (ce_n)      mode = hv ? M_INHB : M_STBY;
    else if (oe_n) mode = (hv && !pgm_n) ? M_PROG : M_ODIS;
    else if (!hv)  mode = M_READ;
    else           mode = pgm_n ? M_VRFY : M_ODIS;
  end

  assign dout_en = (mode == M_READ) || (mode == M_VRFY);
  assign sig_hit = id_hv && (mode == M_READ) && !pgm_n && ((addr >> 1) == '0);
  assign dout    = !dout_en ? 8'h00 :
                   sig_hit  ? (addr[0] ? SIG_DEV : SIG_MFR) : mem[addr];

  assign wr = armed && !pgm_q && pgm_n && setup;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgm_q     <= 1'b1;
      armed     <= 1'b0;
      low_cnt   <= '0;
      pulse_err <= 1'b0;
    end else begin
      pgm_q <= pgm_n;
      if (!setup) begin
        armed <= 1'b0;
      end else if (pgm_q && !pgm_n) begin
        armed   <= 1'b1;
        low_cnt <= CW'(1);
      end else if (armed && !pgm_n) begin
        if (low_cnt == CW'(MAX_LOW)) begin
          armed     <= 1'b0;
          pulse_err <= 1'b1;
        end else begin
          low_cnt <= low_cnt + 1'b1;
        end
      end else if (wr) begin
        armed <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (erase_all) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (wr) begin
      mem[addr] <= mem[addr] & din;
    end
  end
endmodule

module eprom_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       oe_n,
  input logic       pgm_n,
  input logic       vpp_hi,
  input logic       vcc_hi,
  input logic       dout_en,
  input logic [7:0] dout,
  input logic [2:0] mode,
  input logic       pulse_err
);
  a_r2_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_en);
  a_r2_outdis_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n) |-> !dout_en);
  a_r2_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == 8'h00));
  a_r1_en_matches_mode: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (mode == 3'd1 || mode == 3'd4));
  a_r3_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !(vpp_hi && vcc_hi)) |-> dout_en);
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_err |=> pulse_err);
  a_r8_err_from_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_err) |-> $past(!pgm_n));
endmodule

bind eprom_ctl eprom_ctl_chk u_chk (.*);

// File: tb/eprom_ctl_tb.sv
`timescale 1ns/1ps
module eprom_ctl_tb;
  localparam int AW = 4;
  localparam int ML = 4;
  localparam int N  = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, pgm_n = 1, vpp_hi = 0, vcc_hi = 0, id_hv = 0, erase_all = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = 8'hFF;
  logic [7:0] dout;
  logic dout_en, pulse_err;
  logic [2:0] mode;
  logic [7:0] model [N];
  int checks = 0, fails = 0;

  eprom_ctl #(.ADDR_W(AW), .MAX_LOW(ML)) u_dut (.*);

  always #2.5 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_mode(logic c, logic o, logic p, logic v1, logic v2);
    logic h = v1 & v2;
    if (c) return h ? 3'd5 : 3'd0;
    if (o) return (h && !p) ? 3'd3 : 3'd2;
    if (!h) return 3'd1;
    return p ? 3'd4 : 3'd2;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0; ce_n = 1; oe_n = 1; pgm_n = 1;
    vpp_hi = 0; vcc_hi = 0; id_hv = 0; erase_all = 0;
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < N; i++) model[i] = 8'hFF;
  endtask

  task automatic pulse(logic [AW-1:0] a, logic [7:0] d, int low, logic c, logic v1, logic v2);
    @(negedge clk);
    ce_n = c; oe_n = 1; vpp_hi = v1; vcc_hi = v2; pgm_n = 1; addr = a; din = d;
    @(negedge clk); pgm_n = 0;
    repeat (low) @(negedge clk);
    pgm_n = 1;
    @(negedge clk);
    ce_n = 1; vpp_hi = 0; vcc_hi = 0;
  endtask

  task automatic read_all(string req);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      ce_n = 0; oe_n = 0; vpp_hi = 0; vcc_hi = 0; id_hv = 0; addr = AW'(i);
      #1 check(req, dout, model[i]);
    end
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R4: erased after reset
    read_all("R4 reset");
    check("R8 reset", {7'd0, pulse_err}, 8'd0);

    // R1/R2: exhaustive mode sweep
    for (int v = 0; v < 32; v++) begin
      @(negedge clk);
      {ce_n, oe_n, pgm_n, vpp_hi, vcc_hi} = v[4:0];
      addr = '0; id_hv = 0;
      #1;
      check("R1 mode", {5'd0, mode}, {5'd0, exp_mode(v[4], v[3], v[2], v[1], v[0])});
      check("R2 en", {7'd0, dout_en},
            {7'd0, exp_mode(v[4], v[3], v[2], v[1], v[0]) inside {3'd1, 3'd4}});
      if (!dout_en) check("R2 idle zero", dout, 8'h00);
    end
    do_reset();

    // R5: first programming pass
    for (int i = 0; i < N; i++) begin
      logic [7:0] d = 8'((i * 37 + 5) ^ 8'hA3);
      pulse(AW'(i), d, 1 + (i % ML), 0, 1, 1);
      model[i] = model[i] & d;
    end
    read_all("R5 pass1");
    // R5: second pass only clears
    for (int i = 0; i < N; i++) begin
      logic [7:0] d = 8'(~(i * 11));
      pulse(AW'(i), d, 2, 0, 1, 1);
      model[i] = model[i] & d;
    end
    read_all("R5 pass2");

    // R6: verify mode
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      ce_n = 0; oe_n = 0; pgm_n = 1; vpp_hi = 1; vcc_hi = 1; addr = AW'(i);
      #1 check("R6 verify", dout, model[i]);
    end

    // R7: inhibit and single-flag pulses leave array alone
    pulse(AW'(3), 8'h00, 2, 1, 1, 1);
    pulse(AW'(4), 8'h00, 2, 0, 1, 0);
    pulse(AW'(5), 8'h00, 2, 0, 0, 1);
    read_all("R7 no change");

    // R3: read ignores pgm_n and single supply flag
    @(negedge clk);
    ce_n = 0; oe_n = 0; pgm_n = 0; vpp_hi = 1; vcc_hi = 0; addr = AW'(7);
    #1 check("R3 dontcare", dout, model[7]);
    @(negedge clk); pgm_n = 1; vpp_hi = 0; vcc_hi = 1;
    #1 check("R3 dontcare2", dout, model[7]);

    // R9: signature
    @(negedge clk);
    ce_n = 0; oe_n = 0; pgm_n = 0; vpp_hi = 0; vcc_hi = 0; id_hv = 1; addr = AW'(0);
    #1 check("R9 mfr", dout, 8'h8F);
    @(negedge clk); addr = AW'(1);
    #1 check("R9 dev", dout, 8'h86);
    @(negedge clk); addr = AW'(2);
    #1 check("R9 upper addr", dout, model[2]);
    @(negedge clk); addr = AW'(1); pgm_n = 1;
    #1 check("R9 pgm high", dout, model[1]);
    @(negedge clk); id_hv = 0; addr = AW'(0); pgm_n = 0;
    #1 check("R9 no id", dout, model[0]);
    @(negedge clk); ce_n = 1; oe_n = 1; pgm_n = 1;

    // R8: exactly MAX_LOW is fine, one more errors and is dropped
    pulse(AW'(6), 8'h0F, ML, 0, 1, 1);
    model[6] = model[6] & 8'h0F;
    check("R8 max ok", {7'd0, pulse_err}, 8'd0);
    pulse(AW'(8), 8'h00, ML + 1, 0, 1, 1);
    check("R8 err set", {7'd0, pulse_err}, 8'd1);
    read_all("R8 dropped");
    repeat (3) @(negedge clk);
    check("R8 sticky", {7'd0, pulse_err}, 8'd1);

    // R4: erase_all
    @(negedge clk); erase_all = 1;
    @(negedge clk); erase_all = 0;
    for (int i = 0; i < N; i++) model[i] = 8'hFF;
    read_all("R4 erase");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule